// File: doc/BRIEF.md
# PHY Management Register Model

This block models the management register set of an Ethernet PHY, as a MAC-side controller sees it. Software first loads a target word that names a PHY address and a register number. It then reads the selected register from a read-data port, or updates it with a one-cycle pulse on a write-data port. The model holds a control register and an advertisement register. It returns fixed identifier words and builds the status and link-partner words from a link-up input. Diagnostic registers and undefined register numbers read as zero. An access whose PHY address is not the one configured by parameter reads as all ones, and a write to it does nothing.

Read data is combinational from the current target and register state. A write pulse acts on the target that was held before the clock edge that takes it. The ports are plain control and data pins with no back-pressure. The block accepts one write pulse per cycle and offers read data in every cycle. No serial management signalling is included.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After reset the target word is zero, so with the default configured address 1 a read returns 0xFFFF. The control register holds 0x3100 (bit 8 full duplex, bit 12 autonegotiation enable, bit 13 speed 100) and the advertisement register holds 0x01E1.
- R2: When the PHY address field differs from the configured address, the read data is 0xFFFF and a write pulse changes no register.
- R3: Register 1 (status) reads 0x7848, with bit 2 set exactly while `link_up_i` is high (0x784C).
- R4: Register 5 (link partner) reads 0x01E1 while `link_up_i` is high and 0x0080 while it is low, following the input in the same cycle without any reset.
- R5: Registers 2 and 3 read the identifier parameters `ID_HI` and `ID_LO`.
- R6: A write to register 0 with bit 15 clear stores the written value, which is visible on the read port in the next cycle.
- R7: A write to register 0 with bit 15 set stores nothing and returns both the control register (0x3100) and the advertisement register (0x01E1) to their reset values.
- R8: A write to register 4 stores the value in the advertisement register.
- R9: Writes to registers 1, 2, 3, 5 and 6 have no effect on what they read.
- R10: Register 6, every register number from 7 to 255, and in particular the diagnostic block at 16 and above, read as 0x0000.
- R11: The PHY address field is bits [15:8] and the register number is bits [7:0] of the target word. A target write takes effect at the next edge, and a write pulse in the same cycle still uses the previous target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up_i | input | 1 | Current link state from the line side |
| tgt_we_i | input | 1 | Load pulse for the target word |
| tgt_wdata_i | input | 16 | Target word: PHY address field and register number field |
| wr_valid_i | input | 1 | One-cycle write pulse for the selected register |
| wr_data_i | input | 16 | Data written by the write pulse |
| rd_data_o | output | 16 | Contents of the selected register, or 0xFFFF on an address miss |

## Verification
Two situations are hard to reach. The first is a write pulse in the same cycle as a target load, where the write must land in the old register. The bench loads the advertisement target, then drives both strobes on one edge and reads both registers afterwards. The second is a soft reset that must also restore the advertisement register, which is not the register addressed. To reach it, the stimulus changes the advertisement value, issues the reset through the control register, and then moves the target back to register 4 to read it. The link input is toggled while the status and link-partner registers are selected, so that the same-cycle response is observed.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int WORD_W = 16;

  // register numbers
  localparam int RN_CTRL = 0;
  localparam int RN_STAT = 1;
  localparam int RN_ID_HI = 2;
  localparam int RN_ID_LO = 3;
  localparam int RN_ADV = 4;
  localparam int RN_PARTNER = 5;

  // control bits
  localparam int CB_SOFT_RST = 15;
  localparam int CB_SPEED100 = 13;
  localparam int CB_AN_EN = 12;
  localparam int CB_FULL_DUP = 8;

  // status bits
  localparam int SB_TX100_FD = 14;
  localparam int SB_TX100_HD = 13;
  localparam int SB_T10_FD = 12;
  localparam int SB_T10_HD = 11;
  localparam int SB_PRE_SUPP = 6;
  localparam int SB_AN_ABLE = 3;
  localparam int SB_LINK = 2;

  // ability bits, shared by advertisement and partner words
  localparam int AB_TX100_FD = 8;
  localparam int AB_TX100 = 7;
  localparam int AB_T10_FD = 6;
  localparam int AB_T10 = 5;
  localparam int AB_SEL_CSMA = 0;

  localparam logic [WORD_W-1:0] CTRL_INIT =
    WORD_W'((1 << CB_SPEED100) | (1 << CB_AN_EN) | (1 << CB_FULL_DUP));

  localparam logic [WORD_W-1:0] STAT_FIXED =
    WORD_W'((1 << SB_TX100_FD) | (1 << SB_TX100_HD) | (1 << SB_T10_FD) |
            (1 << SB_T10_HD) | (1 << SB_PRE_SUPP) | (1 << SB_AN_ABLE));

  localparam logic [WORD_W-1:0] ADV_INIT =
    WORD_W'((1 << AB_TX100_FD) | (1 << AB_TX100) | (1 << AB_T10_FD) |
            (1 << AB_T10) | (1 << AB_SEL_CSMA));

  localparam logic [WORD_W-1:0] PARTNER_DOWN = WORD_W'(1 << AB_TX100);

  localparam logic [WORD_W-1:0] PARTNER_UP =
    PARTNER_DOWN | WORD_W'((1 << AB_TX100_FD) | (1 << AB_T10_FD) |
                           (1 << AB_T10) | (1 << AB_SEL_CSMA));

  function automatic logic [WORD_W-1:0] partner_word(input logic up);
    return up ? PARTNER_UP : PARTNER_DOWN;
  endfunction

  function automatic logic [WORD_W-1:0] status_word(input logic up);
    logic [WORD_W-1:0] w;
    w = STAT_FIXED;
    w[SB_LINK] = up;
    return w;
  endfunction

endpackage

// File: rtl/phy_tgt_reg.sv
module phy_tgt_reg #(
  parameter int TGT_W    = 16,
  parameter int FIELD_W  = 8,
  parameter int ADDR_POS = 8,
  parameter int REG_POS  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [TGT_W-1:0]   wdata_i,
  output logic [FIELD_W-1:0] phy_addr_o,
  output logic [FIELD_W-1:0] reg_num_o
);

  logic [FIELD_W-1:0] addr_q, reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      reg_q  <= '0;
    end else if (we_i) begin
      addr_q <= wdata_i[ADDR_POS +: FIELD_W];
      reg_q  <= wdata_i[REG_POS +: FIELD_W];
    end
  end

  assign phy_addr_o = addr_q;
  assign reg_num_o  = reg_q;

endmodule

// File: rtl/phy_ctrl_regs.sv
module phy_ctrl_regs
  import phy_mgmt_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [FIELD_W-1:0] reg_num_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  ctrl_o,
  output logic [WORD_W-1:0]  adv_o
);

  logic [WORD_W-1:0] ctrl_q, adv_q;
  int unsigned       sel;

  assign sel = int'(reg_num_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_INIT;
      adv_q  <= ADV_INIT;
    end else if (wr_en_i) begin
      if (sel == RN_CTRL) begin
        if (wdata_i[CB_SOFT_RST]) begin
          ctrl_q <= CTRL_INIT;
          adv_q  <= ADV_INIT;
        end else begin
          ctrl_q <= wdata_i;
        end
      end else if (sel == RN_ADV) begin
        adv_q <= wdata_i;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign adv_o  = adv_q;

endmodule

// File: rtl/phy_rd_mux.sv
module phy_rd_mux
  import phy_mgmt_pkg::*;
#(
  parameter int                FIELD_W = 8,
  parameter logic [WORD_W-1:0] ID_HI   = 16'h0022,
  parameter logic [WORD_W-1:0] ID_LO   = 16'h5512
) (
  input  logic               hit_i,
  input  logic [FIELD_W-1:0] reg_num_i,
  input  logic               link_i,
  input  logic [WORD_W-1:0]  ctrl_i,
  input  logic [WORD_W-1:0]  adv_i,
  output logic [WORD_W-1:0]  rd_data_o
);

  int unsigned sel;
  assign sel = int'(reg_num_i);

  always_comb begin
    rd_data_o = '0;
    if (!hit_i) begin
      rd_data_o = '1;
    end else begin
      case (sel)
        RN_CTRL:    rd_data_o = ctrl_i;
        RN_STAT:    rd_data_o = status_word(link_i);
        RN_ID_HI:   rd_data_o = ID_HI;
        RN_ID_LO:   rd_data_o = ID_LO;
        RN_ADV:     rd_data_o = adv_i;
        RN_PARTNER: rd_data_o = partner_word(link_i);
        default:    rd_data_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int                PHY_ADDR = 1,
  parameter int                TGT_W    = 16,
  parameter int                FIELD_W  = 8,
  parameter int                ADDR_POS = 8,
  parameter int                REG_POS  = 0,
  parameter logic [WORD_W-1:0] ID_HI    = 16'h0022,
  parameter logic [WORD_W-1:0] ID_LO    = 16'h5512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_up_i,
  input  logic              tgt_we_i,
  input  logic [TGT_W-1:0]  tgt_wdata_i,
  input  logic              wr_valid_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o
);

  localparam logic [FIELD_W-1:0] OWN_ADDR = FIELD_W'(PHY_ADDR);

  logic [FIELD_W-1:0] phy_addr, reg_num;
  logic [WORD_W-1:0]  ctrl_w, adv_w;
  logic               hit;

  phy_tgt_reg #(
    .TGT_W(TGT_W), .FIELD_W(FIELD_W), .ADDR_POS(ADDR_POS), .REG_POS(REG_POS)
  ) tgt_i (
    .clk(clk), .rst_n(rst_n), .we_i(tgt_we_i), .wdata_i(tgt_wdata_i),
    .phy_addr_o(phy_addr), .reg_num_o(reg_num)
  );

  assign hit = (phy_addr == OWN_ADDR);

  phy_ctrl_regs #(.FIELD_W(FIELD_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_valid_i & hit),
    .reg_num_i(reg_num), .wdata_i(wr_data_i),
    .ctrl_o(ctrl_w), .adv_o(adv_w)
  );

  phy_rd_mux #(.FIELD_W(FIELD_W), .ID_HI(ID_HI), .ID_LO(ID_LO)) mux_i (
    .hit_i(hit), .reg_num_i(reg_num), .link_i(link_up_i),
    .ctrl_i(ctrl_w), .adv_i(adv_w), .rd_data_o(rd_data_o)
  );

endmodule

// File: rtl/phy_mgmt_regs_chk.sv
module phy_mgmt_regs_chk #(
  parameter int PHY_ADDR = 1,
  parameter int TGT_W    = 16,
  parameter int FIELD_W  = 8,
  parameter int ADDR_POS = 8,
  parameter int REG_POS  = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              link_up_i,
  input logic              tgt_we_i,
  input logic [TGT_W-1:0]  tgt_wdata_i,
  input logic              wr_valid_i,
  input logic [15:0]       wr_data_i,
  input logic [15:0]       rd_data_o
);

  logic [TGT_W-1:0]   shadow;
  logic [FIELD_W-1:0] s_addr, s_reg;
  logic               s_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) shadow <= '0;
    else if (tgt_we_i) shadow <= tgt_wdata_i;
  end

  assign s_addr = shadow[ADDR_POS +: FIELD_W];
  assign s_reg  = shadow[REG_POS +: FIELD_W];
  assign s_hit  = (s_addr == FIELD_W'(PHY_ADDR));

  AST_MISS_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    !s_hit |-> rd_data_o == 16'hFFFF); // R2

  AST_STATUS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && s_reg == FIELD_W'(1)) |-> rd_data_o[2] == link_up_i); // R3

  AST_PARTNER_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && s_reg == FIELD_W'(5)) |->
      rd_data_o == (link_up_i ? 16'h01E1 : 16'h0080)); // R4

  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !tgt_we_i && s_hit && s_reg == '0 && !wr_data_i[15]) |=>
      rd_data_o == $past(wr_data_i)); // R6

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_i && !tgt_we_i && s_hit && s_reg == '0 && wr_data_i[15]) |=>
      rd_data_o == 16'h3100); // R7

  AST_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (s_hit && s_reg >= FIELD_W'(6)) |-> rd_data_o == 16'h0000); // R10

endmodule

bind phy_mgmt_regs phy_mgmt_regs_chk #(
  .PHY_ADDR(PHY_ADDR), .TGT_W(TGT_W), .FIELD_W(FIELD_W),
  .ADDR_POS(ADDR_POS), .REG_POS(REG_POS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .link_up_i(link_up_i), .tgt_we_i(tgt_we_i),
  .tgt_wdata_i(tgt_wdata_i), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o)
);

// File: tb/phy_mgmt_regs_tb_top.sv
module phy_mgmt_regs_tb_top;

  localparam logic [15:0] ID_HI = 16'h0022;
  localparam logic [15:0] ID_LO = 16'h5512;
  localparam logic [1:0] OP_TGT = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_RD  = 2'd2;
  localparam int VEC_N = 43;

  // {op, link, req, arg, expected}
  localparam logic [38:0] VEC [VEC_N] = '{
    {OP_TGT, 1'b0, 4'd0,  16'h0100, 16'h0000},
    {OP_RD,  1'b0, 4'd1,  16'h0000, 16'h3100}, // R1
    {OP_TGT, 1'b0, 4'd0,  16'h0104, 16'h0000},
    {OP_RD,  1'b0, 4'd1,  16'h0000, 16'h01E1}, // R1
    {OP_TGT, 1'b0, 4'd0,  16'h0101, 16'h0000},
    {OP_RD,  1'b0, 4'd3,  16'h0000, 16'h7848}, // R3
    {OP_RD,  1'b1, 4'd3,  16'h0000, 16'h784C}, // R3
    {OP_TGT, 1'b1, 4'd0,  16'h0105, 16'h0000},
    {OP_RD,  1'b1, 4'd4,  16'h0000, 16'h01E1}, // R4
    {OP_RD,  1'b0, 4'd4,  16'h0000, 16'h0080}, // R4
    {OP_TGT, 1'b0, 4'd0,  16'h0102, 16'h0000},
    {OP_RD,  1'b0, 4'd5,  16'h0000, ID_HI},    // R5
    {OP_WR,  1'b0, 4'd0,  16'hAAAA, 16'h0000},
    {OP_RD,  1'b0, 4'd9,  16'h0000, ID_HI},    // R9
    {OP_TGT, 1'b0, 4'd0,  16'h0103, 16'h0000},
    {OP_RD,  1'b0, 4'd5,  16'h0000, ID_LO},    // R5
    {OP_TGT, 1'b0, 4'd0,  16'h0100, 16'h0000},
    {OP_WR,  1'b0, 4'd0,  16'h1000, 16'h0000},
    {OP_RD,  1'b0, 4'd6,  16'h0000, 16'h1000}, // R6
    {OP_TGT, 1'b0, 4'd0,  16'h0104, 16'h0000},
    {OP_WR,  1'b0, 4'd0,  16'h0061, 16'h0000},
    {OP_RD,  1'b0, 4'd8,  16'h0000, 16'h0061}, // R8
    {OP_TGT, 1'b0, 4'd0,  16'h0100, 16'h0000},
    {OP_WR,  1'b0, 4'd0,  16'h8000, 16'h0000},
    {OP_RD,  1'b0, 4'd7,  16'h0000, 16'h3100}, // R7
    {OP_TGT, 1'b0, 4'd0,  16'h0104, 16'h0000},
    {OP_RD,  1'b0, 4'd7,  16'h0000, 16'h01E1}, // R7
    {OP_TGT, 1'b1, 4'd0,  16'h0105, 16'h0000},
    {OP_WR,  1'b1, 4'd0,  16'hFFFF, 16'h0000},
    {OP_RD,  1'b1, 4'd9,  16'h0000, 16'h01E1}, // R9
    {OP_TGT, 1'b0, 4'd0,  16'h0106, 16'h0000},
    {OP_RD,  1'b0, 4'd10, 16'h0000, 16'h0000}, // R10
    {OP_TGT, 1'b0, 4'd0,  16'h0111, 16'h0000},
    {OP_RD,  1'b0, 4'd10, 16'h0000, 16'h0000}, // R10
    {OP_TGT, 1'b0, 4'd0,  16'h01FF, 16'h0000},
    {OP_RD,  1'b0, 4'd10, 16'h0000, 16'h0000}, // R10
    {OP_TGT, 1'b0, 4'd0,  16'h0200, 16'h0000},
    {OP_RD,  1'b0, 4'd2,  16'h0000, 16'hFFFF}, // R2
    {OP_WR,  1'b0, 4'd0,  16'h0000, 16'h0000},
    {OP_TGT, 1'b0, 4'd0,  16'h0100, 16'h0000},
    {OP_RD,  1'b0, 4'd2,  16'h0000, 16'h3100}, // R2
    {OP_TGT, 1'b0, 4'd0,  16'h0501, 16'h0000},
    {OP_RD,  1'b0, 4'd11, 16'h0000, 16'hFFFF}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_up = 1'b0;
  logic        tgt_we = 1'b0;
  logic [15:0] tgt_wdata = '0;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  phy_mgmt_regs dut_i (
    .clk(clk), .rst_n(rst_n), .link_up_i(link_up), .tgt_we_i(tgt_we),
    .tgt_wdata_i(tgt_wdata), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .rd_data_o(rd_data)
  );

  task automatic check(input int req, input logic [15:0] exp);
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL R%0d: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic set_tgt(input logic [15:0] w);
    tgt_we = 1'b1; tgt_wdata = w;
    @(negedge clk);
    tgt_we = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(1, 16'hFFFF); // R1: target cleared, address 0 misses

    for (int i = 0; i < VEC_N; i++) begin
      link_up = VEC[i][36];
      case (VEC[i][38:37])
        OP_TGT:  set_tgt(VEC[i][31:16]);
        OP_WR:   wr(VEC[i][31:16]);
        default: check(int'(VEC[i][35:32]), VEC[i][15:0]);
      endcase
    end

    // R4: partner word follows link with no clock edge in between
    set_tgt(16'h0105);
    link_up = 1'b1; check(4, 16'h01E1);
    link_up = 1'b0; check(4, 16'h0080);

    // R11: data write in the same cycle as a target load uses the old target
    set_tgt(16'h0104);
    tgt_we = 1'b1; tgt_wdata = 16'h0100;
    wr_valid = 1'b1; wr_data = 16'h00A1;
    @(negedge clk);
    tgt_we = 1'b0; wr_valid = 1'b0;
    check(11, 16'h3100);
    set_tgt(16'h0104);
    check(11, 16'h00A1);

    // R2: write to other address leaves advertisement alone
    set_tgt(16'h0304);
    wr(16'h0000);
    set_tgt(16'h0104);
    check(2, 16'h00A1);

    // R1: hardware reset restores control after a stored change
    set_tgt(16'h0100);
    wr(16'h0100);
    check(6, 16'h0100);
    do_reset();
    check(1, 16'hFFFF);
    set_tgt(16'h0100);
    check(1, 16'h3100);
    set_tgt(16'h0104);
    check(1, 16'h01E1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule